// File: doc/BRIEF.md
# Platform System Register Bank

This block is a small bank of platform registers that sits on a simple 32-bit register bus. The bus has a byte offset, a write strobe, write data and read data. The bank gathers the scattered board-level controls and observations into one address window:
- a read-only identification word that carries the board number;
- an eight-bit user LED register whose bits drive output pins;
- a volatile flag word and a non-volatile flag word, each updated through its own pair of set-bit and clear-bit offsets;
- a read-only card status word fed from synchronized pins;
- a flash write-protect control pin;
- a strap that says which daughterboard site is the master;
- two free-running prescaled tick counters.

Read data is combinational from the offset. A write takes effect at the next rising clock edge. Offsets are compared in full, so only the exact word offsets below are mapped. The bank has two synchronous active-low resets. `rst_n` returns the volatile state to its reset values. `por_n` is the power-on reset, and it is the only reset that clears the non-volatile flags.

Top module: `sysreg_bank`

## Requirements
- R1: While `rst_n` is low, the LED register, the volatile flags, the flash control bit, the card synchronizer and both tick counters go to zero. A zero flash control bit means `flash_wp_n_o` is low, so the flash is protected.
- R2: A read at offset 0x030 returns the volatile flags. A write to 0x030 ORs the written ones into the flags and leaves all other bits unchanged.
- R3: A write to 0x034 clears every volatile flag bit that is written as one, and a read at 0x034 returns the current flags. When a set and a clear of the same bit arrive as back-to-back writes, the later write decides the bit.
- R4: The non-volatile flags are set and read at 0x038 and cleared at 0x03C, with the same rules as R2 and R3. They keep their value through `rst_n` and are cleared only by `por_n`.
- R5: A write to 0x008 loads wdata[7:0] into the LED register, and bit n drives `led_o[n]` from the next cycle. A read returns the eight bits in [7:0], with zero above them.
- R6: A read at 0x048 returns card-present in bit 0 and card write-protect in bit 1. Each value is taken from its pin after two clock edges of synchronization. Writes to 0x048 are ignored.
- R7: Bit 0 of the register at 0x04C is readable and writable, and drives `flash_wp_n_o` directly. The pin is active-low: 0 means the flash is protected. All other bits read as zero.
- R8: A read at 0x000 returns {ID_REV[3:0], BOARD_NUM[11:0], ID_LOW[15:0]}, which puts the 12-bit board number in bits 27:16. Writes to this offset are ignored.
- R9: A read at 0x060 returns the `master_site_i` pin in bit 14 and zero in every other bit.
- R10: The word at 0x024 counts up once every SLOW_DIV clocks, and the word at 0x05C counts up once every FAST_DIV clocks. Neither counter can be written.
- R11: Reads from any unmapped offset return zero, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset for volatile state |
| por_n | input | 1 | Synchronous active-low power-on reset for the non-volatile flags |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe; the write commits at the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| card_present_i | input | 1 | Asynchronous card-present pin |
| card_wp_i | input | 1 | Asynchronous card write-protect pin |
| master_site_i | input | 1 | Master-site strap |
| led_o | output | LED_W | User LED drives |
| flash_wp_n_o | output | 1 | Active-low flash write-protect |

## Verification
The flag words are tried with patterns chosen to tell an OR-update apart from a plain overwrite: a second set that adds low bits to bits already held at the top, and a clear whose ones touch only some of the held bits. Read-back is also done at the clear offset. A set followed at once by a clear of the same bit shows which write wins. An LED write with its upper bits set shows that only the low byte is kept. Writes to the identification, card and unmapped offsets, each followed by a read-back, show that those writes are ignored. The card pins are read one edge and then two edges after they change, which shows the synchronizer depth. Resets are applied one at a time, which separates the volatile state from the non-volatile state.

// File: rtl/sysreg_pkg.sv
// Package: offset map and shared constants for the system register bank.
// Assumes word-aligned byte offsets, compared in full by the decoder.
package sysreg_pkg;
    localparam int unsigned OFFS_W       = 12;
    localparam logic [OFFS_W-1:0] OFF_IDENT   = 12'h000;
    localparam logic [OFFS_W-1:0] OFF_LEDS    = 12'h008;
    localparam logic [OFFS_W-1:0] OFF_SLOWCNT = 12'h024;
    localparam logic [OFFS_W-1:0] OFF_VFSET   = 12'h030;
    localparam logic [OFFS_W-1:0] OFF_VFCLR   = 12'h034;
    localparam logic [OFFS_W-1:0] OFF_NVSET   = 12'h038;
    localparam logic [OFFS_W-1:0] OFF_NVCLR   = 12'h03C;
    localparam logic [OFFS_W-1:0] OFF_CARD    = 12'h048;
    localparam logic [OFFS_W-1:0] OFF_FLASH   = 12'h04C;
    localparam logic [OFFS_W-1:0] OFF_FASTCNT = 12'h05C;
    localparam logic [OFFS_W-1:0] OFF_STRAPS  = 12'h060;
    localparam int unsigned MASTER_BIT   = 14;
endpackage

// File: rtl/sysreg_sync.sv
// Module: multi-bit flop synchronizer.
// Each bit is independent; STAGES flops in series with synchronous
// active-low reset to zero. Assumes the bits need no mutual coherence.
module sysreg_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else begin
                    chain_q[s] <= (s == 0) ? async_i : chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sysreg_tick_ctr.sv
// Module: prescaled free-running counter.
// The count advances by one on every DIV-th clock after reset leaves.
// Assumes DIV >= 1; the count wraps silently at its width.
module sysreg_tick_ctr #(
    parameter int unsigned DIV   = 8,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o
);
    localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    // Prescaler plus count: wrap prescaler and bump the count at its last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/sysreg_flags.sv
// Module: flag word with separate set-bit and clear-bit write strobes.
// Set ORs the data in, clear removes the ones in the data. Only one
// strobe is expected per cycle; if both arrive, clear wins.
module sysreg_flags #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] flags_o
);
    logic [WIDTH-1:0] flags_q;

    // Apply the set or clear strobe to the held flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (clr_i) begin
            flags_q <= flags_q & ~data_i;
        end else if (set_i) begin
            flags_q <= flags_q | data_i;
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/sysreg_bank.sv
// Module: platform system register bank (top).
// Decodes full byte offsets on a 32-bit register bus, owns the LED and
// flash control registers, instantiates the flag words, card synchronizer
// and tick counters, and muxes read data. Assumes one access per cycle
// and that rst_n and por_n are synchronous to clk.
module sysreg_bank #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned LED_W     = 8,
    parameter int unsigned SYNC_STG  = 2,
    parameter int unsigned SLOW_DIV  = 480000,
    parameter int unsigned FAST_DIV  = 2,
    parameter logic [3:0]  ID_REV    = 4'h1,
    parameter logic [11:0] BOARD_NUM = 12'h190,
    parameter logic [15:0] ID_LOW    = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              card_present_i,
    input  logic              card_wp_i,
    input  logic              master_site_i,
    output logic [LED_W-1:0]  led_o,
    output logic              flash_wp_n_o
);
    import sysreg_pkg::*;

    localparam int unsigned DATA_W = 32;
    localparam logic [DATA_W-1:0] IDENT_WORD = {ID_REV, BOARD_NUM, ID_LOW};

    logic [LED_W-1:0]  led_q;
    logic              flash_q;
    logic [DATA_W-1:0] vol_flags;
    logic [DATA_W-1:0] nv_flags;
    logic [1:0]        card_sync;
    logic [DATA_W-1:0] slow_cnt;
    logic [DATA_W-1:0] fast_cnt;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [OFFS_W-1:0] off);
        return a == ADDR_W'(off);
    endfunction

    logic wr_led, wr_flash, wr_vset, wr_vclr, wr_nset, wr_nclr;
    assign wr_led   = wr_en && hit(addr, OFF_LEDS);
    assign wr_flash = wr_en && hit(addr, OFF_FLASH);
    assign wr_vset  = wr_en && hit(addr, OFF_VFSET);
    assign wr_vclr  = wr_en && hit(addr, OFF_VFCLR);
    assign wr_nset  = wr_en && hit(addr, OFF_NVSET);
    assign wr_nclr  = wr_en && hit(addr, OFF_NVCLR);

    // Hold the LED drive value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q <= '0;
        end else if (wr_led) begin
            led_q <= wdata[LED_W-1:0];
        end
    end

    // Hold the flash write-protect control; zero keeps the flash protected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_q <= 1'b0;
        end else if (wr_flash) begin
            flash_q <= wdata[0];
        end
    end

    sysreg_flags #(.WIDTH(DATA_W)) u_vflags (
        .clk(clk), .rst_n(rst_n), .set_i(wr_vset), .clr_i(wr_vclr),
        .data_i(wdata), .flags_o(vol_flags)
    );

    sysreg_flags #(.WIDTH(DATA_W)) u_nvflags (
        .clk(clk), .rst_n(por_n), .set_i(wr_nset), .clr_i(wr_nclr),
        .data_i(wdata), .flags_o(nv_flags)
    );

    sysreg_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_card_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({card_wp_i, card_present_i}), .sync_o(card_sync)
    );

    sysreg_tick_ctr #(.DIV(SLOW_DIV), .CNT_W(DATA_W)) u_slow (
        .clk(clk), .rst_n(rst_n), .count_o(slow_cnt)
    );

    sysreg_tick_ctr #(.DIV(FAST_DIV), .CNT_W(DATA_W)) u_fast (
        .clk(clk), .rst_n(rst_n), .count_o(fast_cnt)
    );

    // Select read data for the addressed offset; unmapped reads give zero.
    always_comb begin
        rdata = '0;
        if (hit(addr, OFF_IDENT))                              rdata = IDENT_WORD;
        else if (hit(addr, OFF_LEDS))                          rdata = DATA_W'(led_q);
        else if (hit(addr, OFF_SLOWCNT))                       rdata = slow_cnt;
        else if (hit(addr, OFF_VFSET) || hit(addr, OFF_VFCLR)) rdata = vol_flags;
        else if (hit(addr, OFF_NVSET) || hit(addr, OFF_NVCLR)) rdata = nv_flags;
        else if (hit(addr, OFF_CARD))                          rdata = DATA_W'(card_sync);
        else if (hit(addr, OFF_FLASH))                         rdata = DATA_W'(flash_q);
        else if (hit(addr, OFF_FASTCNT))                       rdata = fast_cnt;
        else if (hit(addr, OFF_STRAPS))                        rdata[MASTER_BIT] = master_site_i;
    end

    assign led_o        = led_q;
    assign flash_wp_n_o = flash_q;
endmodule

// File: rtl/sysreg_chk.sv
// Module: assertion checker for the system register bank, bound to the top.
// Watches bus writes against the registers and pins they must reach.
module sysreg_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned LED_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [LED_W-1:0]  led_o,
    input logic              flash_wp_n_o,
    input logic [31:0]       vol_flags,
    input logic [31:0]       nv_flags
);
    a_r1_reset_pins: assert property (@(posedge clk)
        !rst_n |=> (led_o == '0 && !flash_wp_n_o && vol_flags == '0));

    a_r2_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(12'h030)) |=>
        ((vol_flags & $past(wdata)) == $past(wdata)));

    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(12'h034)) |=> ((vol_flags & $past(wdata)) == '0));

    a_r4_nv_keep: assert property (@(posedge clk) disable iff (!por_n)
        (!(wr_en && (addr == ADDR_W'(12'h038) || addr == ADDR_W'(12'h03C)))) |=>
        $stable(nv_flags));

    a_r5_led_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(12'h008)) |=> (led_o == $past(wdata[LED_W-1:0])));

    a_r5_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == ADDR_W'(12'h008))) |=> $stable(led_o));

    a_r7_flash_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(12'h04C)) |=> (flash_wp_n_o == $past(wdata[0])));

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(12'h010)) |-> (rdata == '0));
endmodule

bind sysreg_bank sysreg_chk #(.ADDR_W(ADDR_W), .LED_W(LED_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .led_o(led_o), .flash_wp_n_o(flash_wp_n_o),
    .vol_flags(vol_flags), .nv_flags(nv_flags)
);

// File: tb/sim_sysreg_bank.sv
`timescale 1ns/1ps
module sim_sysreg_bank;
    localparam int unsigned SLOW = 8;
    localparam int unsigned FAST = 3;
    localparam logic [31:0] IDW  = {4'h1, 12'h2A7, 16'h0405};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        card_present_i = 1'b0;
    logic        card_wp_i = 1'b0;
    logic        master_site_i = 1'b0;
    logic [7:0]  led_o;
    logic        flash_wp_n_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sysreg_bank #(
        .SLOW_DIV(SLOW), .FAST_DIV(FAST), .ID_REV(4'h1),
        .BOARD_NUM(12'h2A7), .ID_LOW(16'h0405)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .card_present_i(card_present_i),
        .card_wp_i(card_wp_i), .master_site_i(master_site_i),
        .led_o(led_o), .flash_wp_n_o(flash_wp_n_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1 d = rdata;
    endtask

    // Vector table: {is_read, offset, data-or-expected}
    localparam int NV = 19;
    localparam logic [44:0] VEC [NV] = '{
        {1'b0, 12'h030, 32'h0000_00F0},  // R2 set
        {1'b1, 12'h030, 32'h0000_00F0},  // R2 read
        {1'b0, 12'h030, 32'h0000_0003},  // R2 OR in
        {1'b1, 12'h030, 32'h0000_00F3},  // R2
        {1'b0, 12'h034, 32'h0000_0030},  // R3 clear
        {1'b1, 12'h034, 32'h0000_00C3},  // R3 read at clear offset
        {1'b0, 12'h038, 32'h0000_A5A5},  // R4 set
        {1'b0, 12'h03C, 32'h0000_0005},  // R4 clear
        {1'b1, 12'h038, 32'h0000_A5A0},  // R4
        {1'b0, 12'h008, 32'hFFFF_FF3C},  // R5 LED write
        {1'b1, 12'h008, 32'h0000_003C},  // R5
        {1'b0, 12'h04C, 32'h0000_0001},  // R7 release protect
        {1'b1, 12'h04C, 32'h0000_0001},  // R7
        {1'b0, 12'h000, 32'hFFFF_FFFF},  // R8 write ignored
        {1'b1, 12'h000, 32'h12A7_0405},  // R8
        {1'b0, 12'h048, 32'h0000_0003},  // R6 write ignored
        {1'b1, 12'h048, 32'h0000_0000},  // R6
        {1'b0, 12'h010, 32'h1234_5678},  // R11 unmapped write
        {1'b1, 12'h010, 32'h0000_0000}   // R11
    };

    initial begin : watchdog
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 led_o", 32'(led_o), 32'h0);
        check("R1 flash_wp_n_o", 32'(flash_wp_n_o), 32'h0);
        rst_n = 1'b1; por_n = 1'b1;
        bus_read(12'h030, v); check("R1 vol flags", v, 32'h0);
        bus_read(12'h038, v); check("R1 nv flags", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) begin
                bus_read(VEC[i][43:32], v);
                check($sformatf("vector %0d offset %h", i, VEC[i][43:32]), v, VEC[i][31:0]);
            end else begin
                bus_write(VEC[i][43:32], VEC[i][31:0]);
            end
        end
        // R5 and R7 pins
        check("R5 led_o pin", 32'(led_o), 32'h3C);
        check("R7 flash pin", 32'(flash_wp_n_o), 32'h1);

        // R3 later access wins: set then clear bit 8
        bus_write(12'h030, 32'h100);
        bus_write(12'h034, 32'h100);
        bus_read(12'h030, v); check("R3 clear after set", v, 32'hC3);
        bus_write(12'h034, 32'h200);
        bus_write(12'h030, 32'h200);
        bus_read(12'h030, v); check("R3 set after clear", v, 32'h2C3);

        // R6 synchronizer depth
        @(negedge clk);
        card_present_i = 1'b1; card_wp_i = 1'b1; addr = 12'h048;
        @(negedge clk); #1 check("R6 after one edge", rdata, 32'h0);
        @(negedge clk); #1 check("R6 after two edges", rdata, 32'h3);
        card_wp_i = 1'b0;
        repeat (2) @(negedge clk);
        #1 check("R6 present only", rdata, 32'h1);

        // R9 master strap
        master_site_i = 1'b1;
        bus_read(12'h060, v); check("R9 strap high", v, 32'h0000_4000);
        master_site_i = 1'b0;
        bus_read(12'h060, v); check("R9 strap low", v, 32'h0);

        // R10 counter rates and read-only
        bus_read(12'h024, v);
        repeat (SLOW * 3 - 1) @(negedge clk);
        bus_read(12'h024, v2); check("R10 slow rate", v2 - v, 32'd3);
        bus_read(12'h05C, v);
        repeat (FAST * 4 - 1) @(negedge clk);
        bus_read(12'h05C, v2); check("R10 fast rate", v2 - v, 32'd4);
        bus_read(12'h024, v);
        bus_write(12'h024, 32'hFFFF_0000);
        bus_read(12'h024, v2);
        check("R10 slow not writable", 32'(v2[31:16] == 16'h0), 32'h1);

        // R4 nv survives rst_n, volatile cleared (R1)
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(12'h038, v); check("R4 nv kept over rst_n", v, 32'hA5A0);
        bus_read(12'h030, v); check("R1 vol cleared by rst_n", v, 32'h0);
        check("R1 led cleared", 32'(led_o), 32'h0);
        check("R1 flash protected", 32'(flash_wp_n_o), 32'h0);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        bus_read(12'h03C, v); check("R4 nv cleared by por_n", v, 32'h0);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule